// File: doc/BRIEF.md
# Synchronized Two-Wire Serial Clock Generator

This block produces the serial clock for a bus master on a two-wire bus where every device can only pull the clock line low. The line is high only when no device pulls it. The block divides the system clock by a value chosen with a 6-bit rate code. It splits that value into a low count and a high count. It drives the line low through an open-drain pull-down enable for the full low count.

After it releases the line, the block watches the line as it actually is on the bus. It starts its high count only once it sees the line high. It ends the high count early if another device pulls the line low first. The result is that the bus low time follows the slowest device, and a slave can stretch the clock. The bus high time follows the quickest device.

The sensed line passes through a two-flop synchronizer before use. A one-cycle sample strobe marks the start of each counted high phase, which is the point where the other logic should sample the data line.

Top module: `scl_sync_clkgen`

## Requirements
- R1: During and directly after reset, `scl_pull` and `sample_stb` are both 0.
- R2: The rate code selects a divider value from a fixed 64-entry table. Examples of entries: code 0x00 gives 28, 0x01 gives 30, 0x0A gives 104, 0x1F gives 3840, 0x20 gives 20, 0x2F gives 128 and 0x3F gives 2048. The low count is the divider minus half the divider, rounded down, and the high count is half the divider, rounded down.
- R3: Each time `scl_pull` rises, it stays 1 for exactly the low count in cycles. This holds even when the sensed line changes during that time.
- R4: When no other device drives the line, each interval with `scl_pull` at 0 lasts the high count plus 3 cycles. The 3 extra cycles are the two synchronizer cycles and one decision cycle.
- R5: If the line is still low after the block releases it, the block waits and does not count. The released interval then grows by exactly the time the line is held low by the other device.
- R6: If another device pulls the line low while the block is counting its high phase, the block starts its own low phase 3 cycles after the line falls. It does not finish its high count.
- R7: `sample_stb` pulses once per released interval. The pulse comes in the first cycle of the counted high phase, which is 3 cycles after the line goes high. It is never 1 while `scl_pull` is 1.
- R8: A change of the rate code takes effect at the next phase start. A low phase in progress keeps the length it was loaded with, and the following high phase uses the new code.
- R9: While `en` is 0, `scl_pull` and `sample_stb` are 0 from the cycle after `en` falls. A later enable starts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; at 0 the line is released and the counters are cleared |
| rate_code | input | 6 | Divider selection code |
| scl_in | input | 1 | Sensed level of the shared clock line |
| scl_pull | output | 1 | At 1, the pad pulls the clock line low |
| sample_stb | output | 1 | One-cycle pulse at the start of each counted high phase |

## Verification
The bench models the wired-AND line and checks the block under four line behaviours:
- **Free running, at several rate codes:** separates a wrong table entry or a wrong low/high split from correct ones.
- **A stretching slave that holds the line after release:** shows whether the high count truly waits on the sensed level.
- **A faster master that pulls the line low in the middle of the high phase:** shows whether the high phase is cut short and whether the own low phase still runs to its full length.
- **A rate change in the middle of a low phase, and a disable in the middle of a low phase:** show when a new code is loaded and that a restart begins with a full low phase.

// File: rtl/scl_sync_clkgen.sv
module scl_sync_clkgen #(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [5:0] rate_code,
  input  logic       scl_in,
  output logic       scl_pull,
  output logic       sample_stb
);

  typedef enum logic [1:0] {PH_OFF, PH_LOW, PH_WAIT, PH_HIGH} phase_t;

  function automatic int divider_of(input logic [5:0] c);
    int d;
    case (c)
      6'h00: d = 28;   6'h01: d = 30;   6'h02: d = 34;   6'h03: d = 40;
      6'h04: d = 44;   6'h05: d = 48;   6'h06: d = 56;   6'h07: d = 68;
      6'h08: d = 80;   6'h09: d = 88;   6'h0A: d = 104;  6'h0B: d = 128;
      6'h0C: d = 144;  6'h0D: d = 160;  6'h0E: d = 192;  6'h0F: d = 240;
      6'h10: d = 288;  6'h11: d = 320;  6'h12: d = 384;  6'h13: d = 480;
      6'h14: d = 576;  6'h15: d = 640;  6'h16: d = 768;  6'h17: d = 960;
      6'h18: d = 1152; 6'h19: d = 1280; 6'h1A: d = 1536; 6'h1B: d = 1920;
      6'h1C: d = 2304; 6'h1D: d = 2560; 6'h1E: d = 3072; 6'h1F: d = 3840;
      6'h20: d = 20;   6'h21: d = 22;   6'h22: d = 24;   6'h23: d = 26;
      6'h24: d = 28;   6'h25: d = 32;   6'h26: d = 36;   6'h27: d = 40;
      6'h28: d = 48;   6'h29: d = 56;   6'h2A: d = 64;   6'h2B: d = 72;
      6'h2C: d = 80;   6'h2D: d = 96;   6'h2E: d = 112;  6'h2F: d = 128;
      6'h30: d = 160;  6'h31: d = 192;  6'h32: d = 224;  6'h33: d = 256;
      6'h34: d = 320;  6'h35: d = 384;  6'h36: d = 448;  6'h37: d = 512;
      6'h38: d = 640;  6'h39: d = 768;  6'h3A: d = 896;  6'h3B: d = 1024;
      6'h3C: d = 1280; 6'h3D: d = 1536; 6'h3E: d = 1792; default: d = 2048;
    endcase
    return d;
  endfunction

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sync;
  logic             scl_s;
  logic [CNT_W-1:0] div, lo_len, hi_len;

  assign div      = CNT_W'(divider_of(rate_code));
  assign hi_len   = div >> 1;
  assign lo_len   = div - hi_len;
  assign scl_s    = sync[1];
  assign scl_pull = (ph == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_OFF;
      cnt        <= '0;
      sync       <= 2'b00;
      sample_stb <= 1'b0;
    end else begin
      sync       <= {sync[0], scl_in};
      sample_stb <= 1'b0;
      if (!en) begin
        ph  <= PH_OFF;
        cnt <= '0;
      end else begin
        case (ph)
          PH_OFF: begin
            ph  <= PH_LOW;
            cnt <= lo_len - 1'b1;
          end
          PH_LOW: begin
            if (cnt == '0) ph <= PH_WAIT;
            else cnt <= cnt - 1'b1;
          end
          PH_WAIT: begin
            if (scl_s) begin
              ph         <= PH_HIGH;
              cnt        <= hi_len - 1'b1;
              sample_stb <= 1'b1;
            end
          end
          default: begin
            if (!scl_s || cnt == '0) begin
              ph  <= PH_LOW;
              cnt <= lo_len - 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_low_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && cnt != '0 && en) |=> scl_pull);

  assert_wait_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && !scl_s && en) |=> (ph == PH_WAIT && !sample_stb));

  assert_low_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> ($past(ph) == PH_HIGH || $past(ph) == PH_OFF));

  assert_stb_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!scl_pull && $past(scl_s)));

  assert_stb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_off_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull && !sample_stb));

endmodule

// File: tb/tb_scl_sync_clkgen.sv
module tb_scl_sync_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [5:0] code = 6'h00;
  logic       ext = 1'b0;
  logic       scl_in;
  logic       pull, stb;

  always #5 clk = ~clk;
  assign scl_in = !(pull || ext);

  scl_sync_clkgen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_code(code),
    .scl_in(scl_in), .scl_pull(pull), .sample_stb(stb)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    lo;
    int    rel;
    int    spos;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_div(input logic [5:0] c);
    case (c)
      6'h00: return 28;
      6'h01: return 30;
      6'h0A: return 104;
      6'h1F: return 3840;
      6'h20: return 20;
      6'h2F: return 128;
      6'h3F: return 2048;
      default: return 0;
    endcase
  endfunction

  // monitor: measures pull-low runs, released runs and strobe position
  bit prevp = 1'b0, lo_v = 1'b0, rel_v = 1'b0;
  int lo_c = 0, rel_c = 0, spos = -1, scount = 0;
  always @(negedge clk) begin
    if (!en || !rst_n) begin
      prevp = 1'b0; lo_v = 1'b0; rel_v = 1'b0;
    end else begin
      if (pull) begin
        if (stb) chk(1'b0, "R7 strobe during low", 1, 0);
        if (!prevp) begin
          if (rel_v && q.size() > 0) begin
            chk(rel_c == q[0].rel, {q[0].tag, " released run"}, rel_c, q[0].rel);
            chk(scount == 1 && spos == q[0].spos, {q[0].tag, " R7 strobe position"}, spos, q[0].spos);
            void'(q.pop_front());
          end
          rel_v = 1'b0; lo_v = 1'b1; lo_c = 1;
        end else begin
          lo_c++;
        end
      end else begin
        if (prevp) begin
          if (lo_v && q.size() > 0)
            chk(lo_c == q[0].lo, {q[0].tag, " R3 low run"}, lo_c, q[0].lo);
          lo_v = 1'b0; rel_v = 1'b1; rel_c = 0; spos = -1; scount = 0;
        end
        if (rel_v) begin
          if (stb) begin spos = rel_c; scount++; end
          rel_c++;
        end
      end
      prevp = pull;
    end
  end

  // other devices on the line: 1 = stretching slave, 2 = faster master
  int mode = 0, ext_s = 6, ext_e = 4, ecnt = 0, hcnt = 0;
  bit pp = 1'b0;
  always @(negedge clk) begin
    if (mode == 1) begin
      if (!pull && pp) begin ext = 1'b1; ecnt = ext_s; end
      else if (ext) begin ecnt--; if (ecnt == 0) ext = 1'b0; end
    end else if (mode == 2) begin
      if (!pull && pp) begin ecnt = ext_e; hcnt = 0; end
      else if (ecnt > 0) begin ecnt--; if (ecnt == 0) begin ext = 1'b1; hcnt = 3; end end
      else if (hcnt > 0) begin hcnt--; if (hcnt == 0) ext = 1'b0; end
    end else begin
      ext = 1'b0;
    end
    pp = pull;
  end

  task automatic quiesce();
    @(negedge clk);
    en = 1'b0; mode = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [5:0] c, input int n, input int m, input string tag);
    int d;
    d = ref_div(c);
    quiesce();
    code = c;
    mode = m;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.lo   = d - d / 2;
      e.rel  = (m == 2) ? ext_e + 3 : d / 2 + 3 + ((m == 1) ? ext_s : 0);
      e.spos = 3 + ((m == 1) ? ext_s : 0);
      e.tag  = tag;
      q.push_back(e);
    end
    en = 1'b1;
    while (q.size() != 0) @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pull == 1'b0, "R1 pull during reset", pull, 0);
    chk(stb == 1'b0, "R1 strobe during reset", stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pull == 1'b0 && stb == 1'b0, "R1 outputs after reset", {pull, stb}, 0);

    run(6'h00, 3, 0, "R2 R4 code 0x00");
    run(6'h01, 2, 0, "R2 R4 code 0x01");
    run(6'h20, 3, 0, "R2 R4 code 0x20");
    run(6'h0A, 2, 0, "R2 R4 code 0x0A");
    run(6'h2F, 2, 0, "R2 R4 code 0x2F");
    run(6'h3F, 2, 0, "R2 R4 code 0x3F");
    run(6'h1F, 2, 0, "R2 R4 code 0x1F");
    run(6'h20, 3, 1, "R5 stretched");
    run(6'h01, 3, 2, "R6 R3 faster master");

    // R8: code change inside a low phase
    quiesce();
    code = 6'h20;
    begin
      exp_t e;
      e.lo = 10; e.rel = 18; e.spos = 3; e.tag = "R8 change mid low";
      q.push_back(e);
      e.lo = 15; e.rel = 18; e.spos = 3; e.tag = "R8 after change";
      q.push_back(e);
    end
    en = 1'b1;
    while (!pull) @(negedge clk);
    code = 6'h01;
    while (q.size() != 0) @(negedge clk);

    // R9: disable in the middle of a low phase
    quiesce();
    code = 6'h2F;
    en = 1'b1;
    while (!pull) @(negedge clk);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(pull == 1'b0 && stb == 1'b0, "R9 release after disable", {pull, stb}, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pull || stb) seen++;
      end
      chk(seen == 0, "R9 stays released", seen, 0);
    end
    run(6'h2F, 1, 0, "R9 restart full low");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule